// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is one output cell of a sum-of-products programmable logic device. It receives the OR of its product terms, the device-wide clock, a global clear term and a global set term. From these it produces the value for its bidirectional pin, the enable for that pin's driver, and a feedback signal that goes back into the AND array. A full device places ten of these cells side by side, all sharing the clock and the two global terms.

Two configuration bits pick the cell's behaviour. One bit chooses whether the pin shows the registered sum or the live combinational sum. The other bit chooses whether the pin is active high or active low. A configuration bit that is programmed reads 0. An erased bit floats high and reads 1, so a cell left fully erased behaves as a combinational, active-high output. The output enable comes from a dedicated product term. When that term is low, the pin becomes an input, and in combinational mode the feedback path carries what the pin receives.

Top module: `olmc_cell`

## Requirements
- R1: Mode encoding: `cfg_s1_i`=0 selects the registered output and 1 selects the combinational output. `cfg_s0_i`=1 selects active high and 0 selects active low. Both bits at 1 (erased) give a combinational, active-high cell.
- R2: The internal register loads `sum_i` at every rising clock edge in every mode, unless it is being cleared or set. In registered mode, `pin_o` is the register value when active high and its complement when active low, and it changes only at clock edges.
- R3: In combinational mode, `pin_o` equals `sum_i` when active high and `~sum_i` when active low, within the same cycle and with no clock edge.
- R4: When `areset_i` is high, the register clears to 0 at once, without waiting for a clock edge.
- R5: `spreset_i` high at a rising edge sets the register to 1 at that edge.
- R6: When `areset_i` and `spreset_i` are high together, the register is 0, because clear has priority over set.
- R7: In registered mode, `fb_o` equals the true register value whatever the polarity, and `pin_i` has no effect on it.
- R8: In combinational mode, `fb_o` equals `pin_i`.
- R9: `pin_oe_o` follows `oe_term_i` in every mode.
- R10: While `rst_ni` is low, the register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared device clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| cfg_s0_i | input | 1 | Polarity bit (1 = active high) |
| cfg_s1_i | input | 1 | Bypass bit (0 = registered, 1 = combinational) |
| sum_i | input | 1 | OR of the cell's product terms |
| areset_i | input | 1 | Global clear product term, asynchronous |
| spreset_i | input | 1 | Global set product term, synchronous |
| oe_term_i | input | 1 | Output enable product term |
| pin_i | input | 1 | Value received from the pin |
| pin_o | output | 1 | Value driven onto the pin |
| pin_oe_o | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback into the AND array |

## Verification
The global clear and the global set can both be active at the same clock edge, and the sum term also competes with them for the register's next value. The bench drives `areset_i` and `spreset_i` high in the same cycle, with `sum_i` at 1, in both polarities. It then expects the pin and the feedback to show a cleared register after the edge. A second case raises the clear in the middle of a cycle and samples the pin before any edge arrives, which shows that the clear takes effect without a clock.

// File: rtl/olmc_pkg.sv
package olmc_pkg;
  typedef enum logic [1:0] {
    MODE_REG_LOW  = 2'b00,
    MODE_REG_HIGH = 2'b01,
    MODE_COM_LOW  = 2'b10,
    MODE_COM_HIGH = 2'b11
  } olmc_mode_e;

  typedef struct packed {
    logic bypass;
    logic act_high;
  } olmc_sel_t;

  function automatic olmc_sel_t decode_mode(olmc_mode_e m);
    olmc_sel_t s;
    s.bypass   = (m == MODE_COM_LOW) || (m == MODE_COM_HIGH);
    s.act_high = (m == MODE_REG_HIGH) || (m == MODE_COM_HIGH);
    return s;
  endfunction
endpackage

// File: rtl/olmc_cfg_decode.sv
module olmc_cfg_decode
  import olmc_pkg::*;
(
  input  logic      s0_i,
  input  logic      s1_i,
  output olmc_sel_t sel_o
);
  olmc_mode_e mode;

  // programmed bit reads 0, erased bit reads 1
  always_comb begin
    mode  = olmc_mode_e'({s1_i, s0_i});
    sel_o = decode_mode(mode);
  end
endmodule

// File: rtl/olmc_reg.sv
module olmc_reg #(
  parameter logic RESET_VAL = 1'b0,
  parameter logic PRESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic clr_i,
  input  logic set_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i) begin
    if (!rst_ni)     q_o <= RESET_VAL;
    else if (clr_i)  q_o <= RESET_VAL;
    else if (set_i)  q_o <= PRESET_VAL;
    else             q_o <= d_i;
  end
endmodule

// File: rtl/olmc_out_mux.sv
module olmc_out_mux
  import olmc_pkg::*;
(
  input  olmc_sel_t sel_i,
  input  logic      sum_i,
  input  logic      q_i,
  input  logic      pin_i,
  output logic      pin_o,
  output logic      fb_o
);
  logic raw;

  always_comb begin
    raw   = sel_i.bypass ? sum_i : q_i;
    pin_o = sel_i.act_high ? raw : ~raw;
    // registered mode feeds back true Q; combinational feeds back the pin
    fb_o  = sel_i.bypass ? pin_i : q_i;
  end
endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
  import olmc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_s0_i,
  input  logic cfg_s1_i,
  input  logic sum_i,
  input  logic areset_i,
  input  logic spreset_i,
  input  logic oe_term_i,
  input  logic pin_i,
  output logic pin_o,
  output logic pin_oe_o,
  output logic fb_o
);
  olmc_sel_t sel;
  logic      reg_q;

  olmc_cfg_decode u_dec (
    .s0_i  (cfg_s0_i),
    .s1_i  (cfg_s1_i),
    .sel_o (sel)
  );

  olmc_reg u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sum_i),
    .clr_i (areset_i),
    .set_i (spreset_i),
    .q_o   (reg_q)
  );

  olmc_out_mux u_mux (
    .sel_i (sel),
    .sum_i (sum_i),
    .q_i   (reg_q),
    .pin_i (pin_i),
    .pin_o (pin_o),
    .fb_o  (fb_o)
  );

  assign pin_oe_o = oe_term_i;
endmodule

// File: rtl/olmc_cell_checker.sv
module olmc_cell_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_s0_i,
  input logic cfg_s1_i,
  input logic sum_i,
  input logic areset_i,
  input logic spreset_i,
  input logic pin_i,
  input logic pin_o,
  input logic fb_o,
  input logic reg_q
);
  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(!areset_i && !spreset_i) && !areset_i) |-> (reg_q == $past(sum_i)));

  a_r5_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(spreset_i && !areset_i) && !areset_i) |-> reg_q);

  a_r6_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    areset_i |-> !reg_q);

  a_r2_reg_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_s1_i |-> (pin_o == (cfg_s0_i ? reg_q : !reg_q)));

  a_r7_reg_fb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_s1_i |-> (fb_o == reg_q));

  a_r8_com_fb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_s1_i |-> (fb_o == pin_i));

  a_r3_com_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_s1_i |-> (pin_o == (cfg_s0_i ? sum_i : !sum_i)));
endmodule

bind olmc_cell olmc_cell_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_s0_i (cfg_s0_i),
  .cfg_s1_i (cfg_s1_i),
  .sum_i    (sum_i),
  .areset_i (areset_i),
  .spreset_i(spreset_i),
  .pin_i    (pin_i),
  .pin_o    (pin_o),
  .fb_o     (fb_o),
  .reg_q    (reg_q)
);

// File: tb/olmc_cell_test.sv
`timescale 1ns/1ps
module olmc_cell_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_s0_i = 1'b1, cfg_s1_i = 1'b0;
  logic sum_i = 1'b0, areset_i = 1'b0, spreset_i = 1'b0;
  logic oe_term_i = 1'b0, pin_i = 1'b0;
  logic pin_o, pin_oe_o, fb_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  olmc_cell uut (.*);

  // {s1,s0,sum,ar,sp,oe,pin, exp_pin, exp_fb}
  localparam int NV = 12;
  localparam logic [8:0] VEC [NV] = '{
    9'b0_1_1_0_0_1_0_1_1,  // R2 reg high load 1
    9'b0_0_0_0_0_1_1_1_0,  // R2 R7 reg low load 0, pin ignored
    9'b0_0_1_0_0_0_0_0_1,  // R2 R9 reg low load 1, oe off
    9'b0_1_0_0_1_1_0_1_1,  // R5 preset beats sum
    9'b0_1_1_1_1_1_0_0_0,  // R6 clear beats set, high
    9'b0_0_1_1_0_1_1_1_0,  // R4 R6 clear, low
    9'b1_1_1_0_0_1_0_1_0,  // R1 R3 R8 erased: comb high
    9'b1_0_1_0_0_1_1_0_1,  // R3 R8 comb low
    9'b1_0_0_0_0_1_0_1_0,  // R3 R8 comb low
    9'b1_1_0_0_0_0_1_0_1,  // R3 R8 R9 comb high, oe off
    9'b0_1_0_0_0_1_1_0_0,  // R7 reg high, pin ignored
    9'b0_1_1_0_0_1_0_1_1   // R2 reg high load 1
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R10 reset reg pin", pin_o, 1'b0);
    check("R10 reset reg fb", fb_o, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {cfg_s1_i, cfg_s0_i, sum_i, areset_i, spreset_i, oe_term_i, pin_i} = VEC[i][8:2];
      @(posedge clk_i);
      #1;
      check($sformatf("R1/R2/R3 vec%0d pin", i), pin_o, VEC[i][1]);
      check($sformatf("R7/R8 vec%0d fb", i), fb_o, VEC[i][0]);
      check($sformatf("R9 vec%0d oe", i), pin_oe_o, VEC[i][3]);
    end

    // R2: registered pin holds between edges
    @(negedge clk_i);
    {cfg_s1_i, cfg_s0_i, areset_i, spreset_i} = 4'b0100;
    sum_i = 1'b1;
    @(posedge clk_i); #1;
    sum_i = 1'b0; #1;
    check("R2 reg holds mid-cycle", pin_o, 1'b1);

    // R4: clear without a clock edge
    areset_i = 1'b1; #0.5;
    check("R4 async clear pin", pin_o, 1'b0);
    check("R4 async clear fb", fb_o, 1'b0);
    @(negedge clk_i) areset_i = 1'b0;

    // R3: combinational follows sum mid-cycle
    {cfg_s1_i, cfg_s0_i} = 2'b10;
    sum_i = 1'b0; #0.5;
    check("R3 comb low sum0", pin_o, 1'b1);
    sum_i = 1'b1; #0.5;
    check("R3 comb low sum1", pin_o, 1'b0);

    // R6: both globals with sum 1, active low registered
    @(negedge clk_i);
    {cfg_s1_i, cfg_s0_i, sum_i, areset_i, spreset_i} = 5'b00111;
    @(posedge clk_i); #1;
    check("R6 clear over set pin", pin_o, 1'b1);
    check("R6 clear over set fb", fb_o, 1'b0);

    // R10: reset mid-run clears register
    @(negedge clk_i);
    {areset_i, spreset_i, sum_i, cfg_s0_i} = 4'b0011;
    @(posedge clk_i); #1;
    check("R2 load before reset", fb_o, 1'b1);
    rst_ni = 1'b0; #0.5;
    check("R10 async reset", fb_o, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule